// File: doc/BRIEF.md
# Event-Triggered Signal-Strength Measurement Sequencer

This block decides when a receiver's signal-strength estimator runs. A 3-bit mode code picks which event starts the measurement schedule, or starts it again. The choices are a gain lock, an enable pin, entry into receive mode, a gain change, a software trigger, or the union of gain change and enable pin. Each restart clears the estimator's accumulator and waits for a settling delay. The block then alternates without end between a measurement window and a wait interval. The wait interval lets each window start on a slot or frame boundary.

All timing is counted in a sample-rate strobe. The settling delay counts one tick per eight strobes. The measurement window and the wait interval count one tick per strobe. The block does not compute power or compensate gain. It only drives the enable, the clear pulse and the result-valid pulse that the power estimator needs.

Top module: `sig_meas_seq`

## Requirements
- R1: A restart comes from the event that `mode` selects. Code 0 selects a rising edge of `gain_lock`. Code 1 selects a rising edge of `en_pin`. Code 2 selects a rising edge of `rx_on`. Code 3 selects any cycle with `gain_chg` high. Code 4 selects any cycle with `sw_trig` high. Code 5 selects either `gain_chg` high or a rising edge of `en_pin`. Events that the mode does not select have no effect.
- R2: The clock edge that sees a restart puts `state_o` into DELAY for the next cycle. In that same cycle `acc_clr` is high, for exactly one cycle.
- R3: DELAY lasts for `dly_cfg`×8 strobes. On the edge that accepts the last of those strobes the state becomes MEAS. When `dly_cfg` is 0, MEAS begins one cycle after DELAY, with no strobe needed.
- R4: A restart in any state, including DELAY, MEAS or WAIT, aborts the current activity and starts the delay afresh.
- R5: After the delay the state alternates without end. MEAS lasts `dur_cfg` strobes and WAIT lasts `wait_cfg` strobes. The state advances only on cycles that carry a strobe.
- R6: `res_vld` is high for one cycle, immediately after the edge that accepts the final strobe of each measurement window.
- R7: When `wait_cfg` is 0, WAIT is skipped. The next measurement window follows the previous one directly, and `res_vld` still marks the end of each window.
- R8: Mode codes 6 and 7 are reserved. They produce no restart from any input.
- R9: After reset the state is IDLE and every output is low. The state codes are IDLE=0, DELAY=1, MEAS=2 and WAIT=3. `meas_en` is high exactly while the state is MEAS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Restart event selection code |
| smp_stb | input | 1 | One-cycle strobe per receive sample |
| gain_lock | input | 1 | Level, high once gain control has locked the gain |
| en_pin | input | 1 | Level from the external enable pin |
| rx_on | input | 1 | Level, high while the receiver is in receive mode |
| gain_chg | input | 1 | Pulse for each gain change |
| sw_trig | input | 1 | Pulse from a software write to the trigger bit |
| dly_cfg | input | DLY_W | Settling delay in units of 8 strobes |
| wait_cfg | input | WAIT_W | Wait interval in strobes |
| dur_cfg | input | DUR_W | Measurement window in strobes |
| state_o | output | 2 | Current sequencer state |
| acc_clr | output | 1 | One-cycle accumulator clear on each restart |
| meas_en | output | 1 | High while the measurement window is open |
| res_vld | output | 1 | One-cycle pulse at the end of each window |

## Verification
The hardest cases to reach from the ports are restarts that land part-way through a schedule. One example is a restart during a prescaled delay whose prescale counter is not at zero. Another is a restart during a wait that follows a back-to-back measurement. The sweep fires each new case's event directly into the running schedule of the previous case. One short case is cut off inside a long delay on purpose. A strobe that arrives only every third cycle keeps the strobe count from lining up with the clock count. The bench derives each expected state from the strobes it has sent, not from cycles.

// File: rtl/sms_pkg.sv
package sms_pkg;

   // Sequencer state codes, visible on the state output
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DELAY = 2'd1,
      ST_MEAS  = 2'd2,
      ST_WAIT  = 2'd3
   } sms_state_e;

   // Restart source selection codes
   localparam logic [2:0] MODE_LOCK    = 3'd0;
   localparam logic [2:0] MODE_PIN     = 3'd1;
   localparam logic [2:0] MODE_RXENTRY = 3'd2;
   localparam logic [2:0] MODE_GAIN    = 3'd3;
   localparam logic [2:0] MODE_SW      = 3'd4;
   localparam logic [2:0] MODE_GAINPIN = 3'd5;

   // Level inputs that restart on a rising edge: lock, pin, receive entry
   localparam int NUM_LVL = 3;
   localparam int LVL_LOCK = 0;
   localparam int LVL_PIN  = 1;
   localparam int LVL_RX   = 2;

endpackage

// File: rtl/sms_evt_sel.sv
module sms_evt_sel
   import sms_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         mode,
   input  logic [NUM_LVL-1:0] lvl_in,
   input  logic               chg_pulse,
   input  logic               sw_pulse,
   output logic               restart
);

   logic [NUM_LVL-1:0] lvl_q;
   logic [NUM_LVL-1:0] rise;

   // One edge detector per level-type source
   for (genvar gi = 0; gi < NUM_LVL; gi++) begin : g_edge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_q[gi] <= 1'b0;
         else        lvl_q[gi] <= lvl_in[gi];
      end
      assign rise[gi] = lvl_in[gi] & ~lvl_q[gi];
   end

   always_comb begin
      case (mode)
         MODE_LOCK:    restart = rise[LVL_LOCK];
         MODE_PIN:     restart = rise[LVL_PIN];
         MODE_RXENTRY: restart = rise[LVL_RX];
         MODE_GAIN:    restart = chg_pulse;
         MODE_SW:      restart = sw_pulse;
         MODE_GAINPIN: restart = chg_pulse | rise[LVL_PIN];
         default:      restart = 1'b0;   // reserved codes stay silent
      endcase
   end

endmodule

// File: rtl/sms_span.sv
// Counts strobes (optionally prescaled by 2**PRE_LOG2) while enabled and
// flags the cycle in which the programmed span completes.
module sms_span #(
   parameter int CW           = 16,
   parameter int PRE_LOG2     = 0,
   parameter bit ZERO_IS_DONE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          stb,
   input  logic [CW-1:0] limit,
   output logic          done
);

   localparam logic [CW-1:0] C_ONE = 1;

   logic          tick;
   logic          last;
   logic [CW-1:0] cnt_q;

   if (CW < 1) begin : g_bad_cw
      $error("sms_span: CW must be at least 1");
   end
   if (PRE_LOG2 < 0 || PRE_LOG2 > 8) begin : g_bad_pre
      $error("sms_span: PRE_LOG2 out of range");
   end

   if (PRE_LOG2 > 0) begin : g_pre
      localparam logic [PRE_LOG2-1:0] P_ONE = 1;
      logic [PRE_LOG2-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             pre_q <= '0;
         else if (!en || done)   pre_q <= '0;
         else if (stb)           pre_q <= pre_q + P_ONE;
      end
      assign tick = stb & (&pre_q);
   end else begin : g_nopre
      assign tick = stb;
   end

   always_comb begin
      if (limit == '0) last = ZERO_IS_DONE ? 1'b1 : tick;
      else             last = tick && (cnt_q == limit - C_ONE);
   end

   assign done = en & last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!en || done)   cnt_q <= '0;
      else if (tick)          cnt_q <= cnt_q + C_ONE;
   end

endmodule

// File: rtl/sig_meas_seq.sv
module sig_meas_seq
   import sms_pkg::*;
#(
   parameter int DLY_W        = 8,
   parameter int WAIT_W       = 16,
   parameter int DUR_W        = 16,
   parameter int DLY_PRE_LOG2 = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode,
   input  logic              smp_stb,
   input  logic              gain_lock,
   input  logic              en_pin,
   input  logic              rx_on,
   input  logic              gain_chg,
   input  logic              sw_trig,
   input  logic [DLY_W-1:0]  dly_cfg,
   input  logic [WAIT_W-1:0] wait_cfg,
   input  logic [DUR_W-1:0]  dur_cfg,
   output logic [1:0]        state_o,
   output logic              acc_clr,
   output logic              meas_en,
   output logic              res_vld
);

   if (DLY_W < 1 || WAIT_W < 1 || DUR_W < 1) begin : g_bad_w
      $error("sig_meas_seq: counter widths must be at least 1");
   end
   if (DLY_PRE_LOG2 < 1 || DLY_PRE_LOG2 > 6) begin : g_bad_pre
      $error("sig_meas_seq: DLY_PRE_LOG2 must lie in 1..6");
   end

   sms_state_e         state_q, state_d;
   logic               restart;
   logic               dly_done, meas_done, wait_done;
   logic               acc_clr_q, res_vld_q;
   logic [NUM_LVL-1:0] lvl_vec;

   assign lvl_vec[LVL_LOCK] = gain_lock;
   assign lvl_vec[LVL_PIN]  = en_pin;
   assign lvl_vec[LVL_RX]   = rx_on;

   sms_evt_sel u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .lvl_in    (lvl_vec),
      .chg_pulse (gain_chg),
      .sw_pulse  (sw_trig),
      .restart   (restart)
   );

   // Settling delay: prescaled strobes, zero means leave at once
   sms_span #(.CW(DLY_W), .PRE_LOG2(DLY_PRE_LOG2), .ZERO_IS_DONE(1'b1)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .en    ((state_q == ST_DELAY) && !restart),
      .stb   (smp_stb),
      .limit (dly_cfg),
      .done  (dly_done)
   );

   // Measurement window: raw strobes, a zero length behaves as one
   sms_span #(.CW(DUR_W), .PRE_LOG2(0), .ZERO_IS_DONE(1'b0)) u_meas (
      .clk   (clk),
      .rst_n (rst_n),
      .en    ((state_q == ST_MEAS) && !restart),
      .stb   (smp_stb),
      .limit (dur_cfg),
      .done  (meas_done)
   );

   // Wait interval: only entered when nonzero
   sms_span #(.CW(WAIT_W), .PRE_LOG2(0), .ZERO_IS_DONE(1'b1)) u_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .en    ((state_q == ST_WAIT) && !restart),
      .stb   (smp_stb),
      .limit (wait_cfg),
      .done  (wait_done)
   );

   always_comb begin
      state_d = state_q;
      if (restart) begin
         state_d = ST_DELAY;
      end else begin
         case (state_q)
            ST_DELAY: if (dly_done)  state_d = ST_MEAS;
            ST_MEAS:  if (meas_done) state_d = (wait_cfg == '0) ? ST_MEAS : ST_WAIT;
            ST_WAIT:  if (wait_done) state_d = ST_MEAS;
            default:  state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         acc_clr_q <= 1'b0;
         res_vld_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         acc_clr_q <= restart;
         res_vld_q <= meas_done & ~restart;
      end
   end

   assign state_o = state_q;
   assign acc_clr = acc_clr_q;
   assign res_vld = res_vld_q;
   assign meas_en = (state_q == ST_MEAS);

endmodule

// File: rtl/sms_chk.sv
module sms_chk
   import sms_pkg::*;
#(
   parameter int WAIT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        mode,
   input logic              smp_stb,
   input logic [WAIT_W-1:0] wait_cfg,
   input logic [1:0]        state_o,
   input logic              acc_clr,
   input logic              meas_en,
   input logic              res_vld
);

   AST_CLR_IN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      acc_clr |-> state_o == ST_DELAY); // R2

   AST_MEAS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_MEAS && $past(state_o) != ST_MEAS)
         |-> ($past(state_o) == ST_DELAY || $past(state_o) == ST_WAIT)); // R3

   AST_WAIT_FOLLOWS_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_WAIT)
         |-> ($past(state_o) == ST_MEAS || $past(state_o) == ST_WAIT)); // R5

   AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(smp_stb) && $past(state_o) == ST_MEAS && !acc_clr) |-> meas_en); // R5

   AST_VLD_ENDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> ($past(state_o) == ST_MEAS && $past(smp_stb))); // R6

   AST_ZERO_WAIT_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && $past(wait_cfg) == '0) |-> meas_en); // R7

   AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) >= 3'd6 && $past(state_o) == ST_IDLE) |-> state_o == ST_IDLE); // R8

endmodule

bind sig_meas_seq sms_chk #(.WAIT_W(WAIT_W)) u_sms_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode     (mode),
   .smp_stb  (smp_stb),
   .wait_cfg (wait_cfg),
   .state_o  (state_o),
   .acc_clr  (acc_clr),
   .meas_en  (meas_en),
   .res_vld  (res_vld)
);

// File: tb/sig_meas_seq_test.sv
`timescale 1ns/1ps
module sig_meas_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic        smp_stb = 1'b0;
   logic        gain_lock = 1'b0, en_pin = 1'b0, rx_on = 1'b0;
   logic        gain_chg = 1'b0, sw_trig = 1'b0;
   logic [7:0]  dly_cfg = 8'd0;
   logic [15:0] wait_cfg = 16'd0;
   logic [15:0] dur_cfg = 16'd1;
   logic [1:0]  state_o;
   logic        acc_clr, meas_en, res_vld;

   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   sig_meas_seq uut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .smp_stb(smp_stb),
      .gain_lock(gain_lock), .en_pin(en_pin), .rx_on(rx_on),
      .gain_chg(gain_chg), .sw_trig(sw_trig),
      .dly_cfg(dly_cfg), .wait_cfg(wait_cfg), .dur_cfg(dur_cfg),
      .state_o(state_o), .acc_clr(acc_clr), .meas_en(meas_en), .res_vld(res_vld)
   );

   task automatic chk(string req, string what, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // src: 0 lock, 1 pin, 2 rx entry, 3 gain change, 4 software trigger
   task automatic set_src(int src, logic v);
      case (src)
         0: gain_lock = v;
         1: en_pin    = v;
         2: rx_on     = v;
         3: gain_chg  = v;
         default: sw_trig = v;
      endcase
   endtask

   function automatic bit selects(int md, int src);
      case (md)
         0: return src == 0;
         1: return src == 1;
         2: return src == 2;
         3: return src == 3;
         4: return src == 4;
         5: return src == 3 || src == 1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      smp_stb = 1'b0;
      for (int k = 0; k < 5; k++) set_src(k, 1'b0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // R1 / R8: one pulse on one source after reset, state observed twice
   task automatic probe(int md, int src);
      string tag;
      int    exp_st;
      tag = (md >= 6) ? "R8" : "R1";
      do_reset();
      mode = md[2:0];
      dly_cfg = 8'd2;
      set_src(src, 1'b1);
      @(negedge clk);
      set_src(src, 1'b0);
      exp_st = selects(md, src) ? 1 : 0;
      chk(tag, $sformatf("state mode%0d src%0d", md, src), int'(state_o), exp_st);
      chk(tag, $sformatf("acc_clr mode%0d src%0d", md, src), int'(acc_clr), exp_st);
      @(negedge clk);
      chk(tag, $sformatf("state hold mode%0d src%0d", md, src), int'(state_o), exp_st);
   endtask

   // Fire an event into whatever is running, then follow the schedule
   // cycle by cycle; expectations come from the count of strobes sent.
   task automatic run_case(int md, int src, int d, int n, int w, int p, int lim);
      int  s, base, len, m, t, r;
      bit  cur_stb;
      int  exp_st, exp_clr, exp_vld;
      string tag;
      @(negedge clk);
      mode = md[2:0];
      dly_cfg = d[7:0];
      dur_cfg = n[15:0];
      wait_cfg = w[15:0];
      smp_stb = 1'b0;
      set_src(src, 1'b1);
      s = 0; base = 0; cur_stb = 1'b0;
      len = 8 * d * p + 3 * (n + w) * p + 6;
      if (lim > 0 && lim < len) len = lim;
      for (int j = 0; j <= len; j++) begin
         @(negedge clk);
         if (j == 0) set_src(src, 1'b0);
         if (j >= 1 && cur_stb) s++;
         if (j == 1 && d == 0) base = cur_stb ? 1 : 0;
         exp_vld = 0;
         if (j == 0) begin
            exp_st = 1; exp_clr = 1; tag = "R2 R4";
         end else if (d > 0 && s < 8 * d) begin
            exp_st = 1; exp_clr = 0; tag = "R3";
         end else begin
            m = s - ((d > 0) ? 8 * d : base);
            t = n + w;
            r = m % t;
            exp_st = (r < n) ? 2 : 3;
            exp_clr = 0;
            exp_vld = (cur_stb && m > 0 && r == (n % t)) ? 1 : 0;
            tag = (w == 0) ? "R7" : "R5";
         end
         chk(tag, $sformatf("state d%0d n%0d w%0d p%0d cyc%0d", d, n, w, p, j),
             int'(state_o), exp_st);
         chk("R9", "meas_en", int'(meas_en), (exp_st == 2) ? 1 : 0);
         chk("R2", "acc_clr", int'(acc_clr), exp_clr);
         chk((w == 0) ? "R6 R7" : "R6",
             $sformatf("res_vld d%0d n%0d w%0d p%0d cyc%0d", d, n, w, p, j),
             int'(res_vld), exp_vld);
         cur_stb = ((j + 1) % p == 0);
         smp_stb = cur_stb;
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R9 watchdog: actual 0 expected 1 (run did not complete)");
      finish_run();
   end

   initial begin
      int nl[3];
      int wl[3];
      int idx;
      nl = '{1, 2, 5};
      wl = '{0, 1, 3};

      // R9: reset state
      do_reset();
      @(negedge clk);
      chk("R9", "reset state", int'(state_o), 0);
      chk("R9", "reset acc_clr", int'(acc_clr), 0);
      chk("R9", "reset meas_en", int'(meas_en), 0);
      chk("R9", "reset res_vld", int'(res_vld), 0);

      // R1, R8: every mode against every source
      for (int md = 0; md < 8; md++)
         for (int src = 0; src < 5; src++)
            probe(md, src);

      // R3, R4, R5, R6, R7: schedule sweep, each case restarting the last
      do_reset();
      idx = 0;
      for (int d = 0; d < 3; d++)
         for (int ni = 0; ni < 3; ni++)
            for (int wi = 0; wi < 3; wi++)
               for (int p = 1; p <= 3; p += 2) begin
                  int md;
                  md = idx % 6;
                  run_case(md, (md == 5) ? 1 : md, d, nl[ni], wl[wi], p, 0);
                  idx++;
               end

      // R4: restart inside a long delay, then a complete schedule
      run_case(3, 3, 3, 2, 1, 1, 10);
      run_case(5, 3, 1, 3, 2, 3, 0);
      run_case(4, 4, 0, 1, 0, 1, 0);

      finish_run();
   end

endmodule